// File: doc/BRIEF.md
# Interrupt and Trap Priority Controller

This block sits beside a processor's instruction sequencer and decides, at each instruction boundary, whether the processor must leave its program to service something. Three classes of request compete: internal trap flags raised by the processor itself, a line-clock/event request from a single dedicated input, and a general device request. Traps are honoured unconditionally. The two external classes are honoured only when the processor's priority mask bit is clear and the processor is running, not halted.

When a request wins, the block issues a one-cycle strobe that tells the sequencer to push the current PC and PS. On the next cycle it issues a service request that carries the vector the sequencer must load from. Trap vectors and the event vector are generated inside the block. The device path first runs a vector-read handshake on the bus. If no reply arrives within a programmable number of cycles, the block raises a halt request instead of servicing the device.

Top module: `intr_prio_ctrl`

## Requirements
- R1: While reset is held and on the first cycles after it, `push_o`, `svc_req_o`, `vec_rd_o` and `halt_req_o` are all low.
- R2: A pending trap is taken whatever the mask bit and the halt state. When several are pending, the lowest index wins. Trap i is serviced with vector 4 + 4*i (trap 0 → 4, trap 3 → 16).
- R3: When any trap flag is set at a boundary, the trap is serviced even if the event and device requests are also active.
- R4: An event request is serviced with vector 64 (octal 100) without any vector read (`vec_rd_o` stays low).
- R5: When the event and device requests are both active and allowed, the event request wins.
- R6: With the mask bit (`prio_mask_i`) at 1, neither external request causes any output activity.
- R7: While `halted_i` is 1, neither external request causes any output activity.
- R8: With `tick_en_i` at 0, the event request is ignored, while a device request is still serviced.
- R9: A device request raises `vec_rd_o` from the cycle after the boundary until the cycle after `vec_valid_i` is seen. The captured `vec_data_i` is the service vector. A reply in the last allowed cycle is still accepted.
- R10: If no reply arrives within TIMEOUT_CYC cycles of `vec_rd_o` being high (default 64), `halt_req_o` pulses for one cycle and neither `push_o` nor `svc_req_o` follows.
- R11: Every service consists of exactly one `push_o` cycle followed immediately by exactly one `svc_req_o` cycle.
- R12: Requests are sampled only on cycles where `boundary_i` is 1 and the block is idle. Requests without a boundary, and boundaries that occur during a vector read or a service sequence, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary; requests are sampled on this cycle |
| trap_pend_i | input | NTRAP (4) | Pending internal trap flags; bit 0 has the highest rank |
| tick_req_i | input | 1 | Line-clock/event request, level sensitive |
| dev_req_i | input | 1 | Device interrupt request, level sensitive |
| prio_mask_i | input | 1 | Processor priority mask bit; 1 blocks external requests |
| tick_en_i | input | 1 | Configuration enable for the event request |
| halted_i | input | 1 | Processor is in halt mode |
| vec_valid_i | input | 1 | Device vector reply strobe |
| vec_data_i | input | VW (16) | Device-supplied vector |
| vec_rd_o | output | 1 | Vector read in progress |
| push_o | output | 1 | Push current PC and PS |
| svc_req_o | output | 1 | Service request; load from `svc_vec_o` |
| svc_vec_o | output | VW (16) | Selected vector |
| halt_req_o | output | 1 | Enter halt mode after a vector-read timeout |

## Verification
A wrong arbitration state shows up at the ports within three cycles of a boundary. The symptoms are a `push_o` where none is expected, a wrong vector in the `svc_req_o` cycle, or `vec_rd_o` rising for a request that should have been an event or trap service. A broken timeout counter shows up as a `vec_rd_o` window whose length differs from TIMEOUT_CYC, or as a missing or misplaced `halt_req_o` pulse. A sequencer stuck outside idle is exposed because the next boundary produces no activity. The directed scenarios measure these windows cycle by cycle against the requirement values.

// File: rtl/intr_prio_pkg.sv
// Package: shared types for the interrupt and trap priority controller.
// Assumes: included first in compile order.
package intr_prio_pkg;

    // Sequencer states of the controller
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VREAD,
        ST_PUSH,
        ST_SVC,
        ST_HALT
    } ctl_state_t;

    // Winning request class at a boundary
    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_TICK,
        SRC_DEV
    } src_kind_t;

endpackage

// File: rtl/intr_prio_pick.sv
// Module: intr_prio_pick
// Combinational arbiter. It ranks pending traps (lowest index first) above the
// event request, and the event request above the device request. External
// requests need the mask bit clear and the processor running.
// Assumes: NTRAP >= 1; the vector values fit in VW bits.
module intr_prio_pick
    import intr_prio_pkg::*;
#(
    parameter int NTRAP     = 4,
    parameter int VW        = 16,
    parameter int TICK_VEC  = 'o100,
    parameter int TRAP_BASE = 4,
    parameter int TRAP_STEP = 4
) (
    input  logic [NTRAP-1:0] trap_pend_i,
    input  logic             tick_req_i,
    input  logic             dev_req_i,
    input  logic             prio_mask_i,
    input  logic             tick_en_i,
    input  logic             halted_i,
    output src_kind_t        kind_o,
    output logic [VW-1:0]    vec_o
);
    localparam int IDXW = (NTRAP > 1) ? $clog2(NTRAP) : 1;

    logic [VW-1:0]   trap_vec_tab [NTRAP];
    logic [IDXW-1:0] trap_sel;
    logic            trap_hit;
    logic            ext_ok;

    // One computed vector per trap source
    for (genvar g = 0; g < NTRAP; g++) begin : g_tvec
        assign trap_vec_tab[g] = VW'(TRAP_BASE + g * TRAP_STEP);
    end

    // Find the lowest-index pending trap
    always_comb begin
        trap_hit = 1'b0;
        trap_sel = '0;
        for (int i = NTRAP - 1; i >= 0; i--) begin
            if (trap_pend_i[i]) begin
                trap_hit = 1'b1;
                trap_sel = IDXW'(i);
            end
        end
    end

    assign ext_ok = !prio_mask_i && !halted_i;

    // Rank the request classes and pick the vector
    always_comb begin
        kind_o = SRC_NONE;
        vec_o  = '0;
        if (trap_hit) begin
            kind_o = SRC_TRAP;
            vec_o  = trap_vec_tab[trap_sel];
        end else if (ext_ok && tick_en_i && tick_req_i) begin
            kind_o = SRC_TICK;
            vec_o  = VW'(TICK_VEC);
        end else if (ext_ok && dev_req_i) begin
            kind_o = SRC_DEV;
        end
    end

endmodule

// File: rtl/intr_vec_timer.sv
// Module: intr_vec_timer
// Counts the cycles of a device vector read. It flags expiry in the
// LIMIT-th cycle of the read.
// Assumes: run rises from a cycle in which it was low; LIMIT >= 1.
module intr_vec_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    // Count while a read runs, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

    // R10: each read starts its window from zero
    a_r10_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/intr_prio_ctrl.sv
// Module: intr_prio_ctrl (top)
// Samples requests at instruction boundaries and runs the service sequence:
// an optional vector read, then a push strobe, then a service request with
// the vector. A vector read that times out ends in a halt request instead.
// Assumes: boundary_i is asserted only for one cycle per boundary; the
// consumer acts on push_o and svc_req_o in the cycles they are high.
module intr_prio_ctrl
    import intr_prio_pkg::*;
#(
    parameter int NTRAP       = 4,
    parameter int VW          = 16,
    parameter int TICK_VEC    = 'o100,
    parameter int TRAP_BASE   = 4,
    parameter int TRAP_STEP   = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic [NTRAP-1:0] trap_pend_i,
    input  logic             tick_req_i,
    input  logic             dev_req_i,
    input  logic             prio_mask_i,
    input  logic             tick_en_i,
    input  logic             halted_i,
    input  logic             vec_valid_i,
    input  logic [VW-1:0]    vec_data_i,
    output logic             vec_rd_o,
    output logic             push_o,
    output logic             svc_req_o,
    output logic [VW-1:0]    svc_vec_o,
    output logic             halt_req_o
);
    ctl_state_t    state;
    src_kind_t     pick_kind;
    logic [VW-1:0] pick_vec;
    logic [VW-1:0] vec_q;
    logic          rd_expired;

    intr_prio_pick #(
        .NTRAP    (NTRAP),
        .VW       (VW),
        .TICK_VEC (TICK_VEC),
        .TRAP_BASE(TRAP_BASE),
        .TRAP_STEP(TRAP_STEP)
    ) u_pick (
        .trap_pend_i(trap_pend_i),
        .tick_req_i (tick_req_i),
        .dev_req_i  (dev_req_i),
        .prio_mask_i(prio_mask_i),
        .tick_en_i  (tick_en_i),
        .halted_i   (halted_i),
        .kind_o     (pick_kind),
        .vec_o      (pick_vec)
    );

    intr_vec_timer #(
        .LIMIT(TIMEOUT_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_VREAD),
        .expired(rd_expired)
    );

    // Service sequencer and vector register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            vec_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (boundary_i) begin
                        unique case (pick_kind)
                            SRC_TRAP, SRC_TICK: begin
                                state <= ST_PUSH;
                                vec_q <= pick_vec;
                            end
                            SRC_DEV:  state <= ST_VREAD;
                            default:  state <= ST_IDLE;
                        endcase
                    end
                end
                ST_VREAD: begin
                    if (vec_valid_i) begin
                        vec_q <= vec_data_i;
                        state <= ST_PUSH;
                    end else if (rd_expired) begin
                        state <= ST_HALT;
                    end
                end
                ST_PUSH: state <= ST_SVC;
                ST_SVC:  state <= ST_IDLE;
                ST_HALT: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign vec_rd_o   = (state == ST_VREAD);
    assign push_o     = (state == ST_PUSH);
    assign svc_req_o  = (state == ST_SVC);
    assign halt_req_o = (state == ST_HALT);
    assign svc_vec_o  = vec_q;

    // R11: a push is always followed by the service request
    a_r11_push_then_svc: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> svc_req_o);

    // R11: a service request is always preceded by a push
    a_r11_svc_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> $past(push_o));

    // R10: a halt request only ends a vector read and is never a push
    a_r10_halt_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o |-> ($past(vec_rd_o) && !$past(vec_valid_i)));

    // R6 R7: a vector read starts only with the mask clear and while running
    a_r6_read_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_rd_o) |-> $past(!prio_mask_i && !halted_i));

    // R12: a vector read starts only from a boundary with no trap pending
    a_r12_read_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_rd_o) |-> $past(boundary_i && !(|trap_pend_i)));

    // R1: at most one control output at a time
    a_r1_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_rd_o, push_o, svc_req_o, halt_req_o}));

endmodule

// File: tb/intr_prio_ctrl_bench.sv
module intr_prio_ctrl_bench;
    localparam int NT = 4;
    localparam int VW = 16;
    localparam int TO = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          boundary;
    logic [NT-1:0] trap_pend;
    logic          tick_req, dev_req, prio_mask, tick_en, halted;
    logic          vec_valid;
    logic [VW-1:0] vec_data;
    logic          vec_rd, push, svc_req, halt_req;
    logic [VW-1:0] svc_vec;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    intr_prio_ctrl u_intr_prio_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary),
        .trap_pend_i(trap_pend),
        .tick_req_i (tick_req),
        .dev_req_i  (dev_req),
        .prio_mask_i(prio_mask),
        .tick_en_i  (tick_en),
        .halted_i   (halted),
        .vec_valid_i(vec_valid),
        .vec_data_i (vec_data),
        .vec_rd_o   (vec_rd),
        .push_o     (push),
        .svc_req_o  (svc_req),
        .svc_vec_o  (svc_vec),
        .halt_req_o (halt_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        boundary = 0; trap_pend = '0; tick_req = 0; dev_req = 0;
        prio_mask = 0; tick_en = 1; halted = 0; vec_valid = 0; vec_data = '0;
    endtask

    function automatic logic [3:0] activity();
        return {vec_rd, push, svc_req, halt_req};
    endfunction

    // Trap or event service: push next cycle, service the cycle after
    task automatic take_direct(input logic [NT-1:0] tp, input bit tk, input bit dv,
                               input bit mk, input bit hl, input bit en,
                               input logic [VW-1:0] exp, input string req);
        @(negedge clk);
        trap_pend = tp; tick_req = tk; dev_req = dv;
        prio_mask = mk; halted = hl; tick_en = en; boundary = 1;
        @(negedge clk);
        boundary = 0;
        chk({req, " R11 push"}, 32'(push), 1);
        chk({req, " no read"}, 32'(vec_rd), 0);
        @(negedge clk);
        chk({req, " R11 svc"}, 32'(svc_req), 1);
        chk({req, " vector"}, 32'(svc_vec), 32'(exp));
        @(negedge clk);
        chk({req, " R11 single"}, 32'(activity()), 0);
        clear_inputs();
    endtask

    // Stimulus that must cause no output activity
    task automatic expect_nothing(input bit with_bnd, input bit tk, input bit dv,
                                  input bit mk, input bit hl, input bit en,
                                  input string req);
        logic [3:0] seen;
        seen = '0;
        @(negedge clk);
        tick_req = tk; dev_req = dv; prio_mask = mk; halted = hl; tick_en = en;
        boundary = with_bnd;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            boundary = 0;
            seen = seen | activity();
        end
        chk(req, 32'(seen), 0);
        clear_inputs();
    endtask

    // Device service with a reply after wait_n further cycles
    task automatic dev_read(input int wait_n, input logic [VW-1:0] data,
                            input bit trap_during, input string req);
        @(negedge clk);
        dev_req = 1; boundary = 1;
        @(negedge clk);
        boundary = 0;
        chk({req, " R9 read starts"}, 32'(vec_rd), 1);
        if (trap_during) begin
            trap_pend = 4'b0001;
            boundary  = 1;
        end
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            boundary = 0;
        end
        chk({req, " R9 read held"}, 32'(vec_rd), 1);
        chk({req, " R12 no push yet"}, 32'(push), 0);
        vec_valid = 1; vec_data = data;
        @(negedge clk);
        vec_valid = 0; dev_req = 0;
        chk({req, " R9 push"}, 32'(push), 1);
        chk({req, " R9 read ends"}, 32'(vec_rd), 0);
        @(negedge clk);
        chk({req, " R9 svc"}, 32'(svc_req), 1);
        chk({req, " R9 vector"}, 32'(svc_vec), 32'(data));
        @(negedge clk);
        @(negedge clk);
        chk({req, " R12 nothing after"}, 32'(activity()), 0);
        clear_inputs();
    endtask

    // Device read without reply ends in a halt request
    task automatic dev_timeout();
        int n;
        logic [3:0] seen;
        @(negedge clk);
        dev_req = 1; boundary = 1;
        @(negedge clk);
        boundary = 0;
        n = 0;
        while (vec_rd && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk("R10 read window", 32'(n), TO);
        chk("R10 halt pulse", 32'(halt_req), 1);
        chk("R10 no push", 32'(push), 0);
        seen = '0;
        @(negedge clk);
        chk("R10 halt single", 32'(halt_req), 0);
        dev_req = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            seen = seen | activity();
        end
        chk("R10 no service", 32'(seen), 0);
        clear_inputs();
    endtask

    task automatic test_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 32'(activity()), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 outputs after reset", 32'(activity()), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        test_reset();
        // R2: lowest index trap, and traps ignore mask and halt
        take_direct(4'b0100, 0, 0, 0, 0, 1, 16'd12, "R2 trap2");
        take_direct(4'b1010, 0, 0, 1, 1, 1, 16'd8, "R2 masked halted");
        // R3: traps beat both external requests
        take_direct(4'b1000, 1, 1, 0, 0, 1, 16'd16, "R3 trap over ext");
        // R4: event vector without a read
        take_direct('0, 1, 0, 0, 0, 1, 16'o100, "R4 event");
        // R5: event over device
        take_direct('0, 1, 1, 0, 0, 1, 16'o100, "R5 event over dev");
        // R6, R7: mask and halt block external requests
        expect_nothing(1, 1, 1, 1, 0, 1, "R6 masked");
        expect_nothing(1, 1, 1, 0, 1, 1, "R7 halted");
        // R8: event disabled; device still taken
        expect_nothing(1, 1, 0, 0, 0, 0, "R8 event disabled");
        tick_req = 1; tick_en = 0;
        dev_read(0, 16'o300, 0, "R8 device with event disabled");
        // R9: immediate reply, and reply in the last cycle with a boundary mid-read
        dev_read(2, 16'h00c4, 0, "R9 short");
        dev_read(TO - 1, 16'h1234, 1, "R9 last cycle R12 busy");
        // R10: timeout
        dev_timeout();
        // R12: no boundary, no service
        expect_nothing(0, 1, 1, 0, 0, 1, "R12 no boundary");
        take_direct(4'b0001, 0, 0, 0, 0, 1, 16'd4, "R12 after idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule